// File: doc/BRIEF.md
# Burst-of-Two Quad-Data-Rate SRAM Core

This block models the storage core of a quad-data-rate SRAM. It has a separate write data port and a separate read data port, and every access is a fixed burst of two words. One fast clock drives the core. Each pair of clock edges forms one command cycle. The first edge of the pair is the command slot, which stands for the rising edge of the main clock. The second edge is the complement slot, which stands for the rising edge of the inverted clock. An internal phase flag tells the two slots apart. The flag starts at the command slot on the first edge after reset.

In the command slot the core samples an active-low read select, an active-low write select and a pair address. A write takes its first data word in the command slot and its second word in the complement slot. A read returns its two words in the two slots of the next command cycle, on a read data port that floats whenever no response is under way. A read and a write can start in the same cycle. Each word address is formed from the pair address plus one low bit that gives the beat number.

If the clock stops, every register keeps its value, and the outputs stay as they are until the clock runs again.

Top module: `qdr_b2_sram`

## Requirements
- R1: After a synchronous reset, `rd_oe` is low and every storage word reads as zero.
- R2: When `wr_sel_n` is low at a command-slot edge, `wdata` at that edge is written to word index 2*`addr`+0.
- R3: The second write beat, taken from `wdata` at the next complement-slot edge, is written to word index 2*`addr`+1, using the address latched in the command slot.
- R4: When `rd_sel_n` is low at a command-slot edge, the word at 2*`addr`+0 appears on `rdata` after the command-slot edge of the next cycle. The word at 2*`addr`+1 appears after the complement-slot edge that follows it.
- R5: `rd_oe` is high during exactly the two slots of a read's response cycle and low in every other slot. `rdata` is high impedance whenever `rd_oe` is low.
- R6: A cycle with both selects high changes no storage word, whatever value `wdata` has, and starts no response.
- R7: A read and a write started in the same command cycle at the same pair address return the contents as they were before that write.
- R8: Reads in consecutive command cycles keep `rd_oe` high without a gap, and each burst returns its own data.
- R9: The beat bit never carries into the pair address. A burst at the highest pair address leaves pair address 0 unchanged.
- R10: While the clock is stopped, `rdata` and `rd_oe` hold their values, and operation resumes with no reinitialisation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; two edges make one command cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_sel_n | input | 1 | Active-low read start, sampled in the command slot |
| wr_sel_n | input | 1 | Active-low write start, sampled in the command slot |
| addr | input | AW | Pair address, sampled in the command slot |
| wdata | input | DW | Write beat: beat 0 in the command slot, beat 1 in the complement slot |
| rdata | output | DW | Read beats; high impedance when no response is active |
| rd_oe | output | 1 | High while `rdata` carries a read beat |

## Verification
The hardest case to reach is a read and a write aimed at the same pair address in the same command cycle. The second write beat lands after the read has already taken its data. Random addresses drawn from a narrow window make these collisions frequent. Directed cycles add reads back to back, a burst at the top pair address, and a clock stop in the middle of a response.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
  // Phase of the current clock edge within one command cycle
  typedef enum logic {
    SLOT_CMD  = 1'b0,
    SLOT_COMP = 1'b1
  } slot_e;
endpackage

// File: rtl/qdr_phase.sv
module qdr_phase
  import qdr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  output slot_e slot
);
  always_ff @(posedge clk) begin
    if (!rst_n) slot <= SLOT_CMD;
    else        slot <= (slot == SLOT_CMD) ? SLOT_COMP : SLOT_CMD;
  end
endmodule

// File: rtl/qdr_wr_path.sv
module qdr_wr_path #(
  parameter int AW = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_slot,
  input  logic        wr_sel_n,
  input  logic [AW-1:0] addr,
  output logic        we,
  output logic [AW:0] waddr
);
  logic          beat1_pend;
  logic [AW-1:0] beat1_pair;

  // Word index of a beat inside a pair: no carry out of the beat bit
  function automatic logic [AW:0] word_of(input logic [AW-1:0] pair, input logic beat);
    return {pair, beat};
  endfunction

  always_comb begin
    we    = cmd_slot ? !wr_sel_n : beat1_pend;
    waddr = cmd_slot ? word_of(addr, 1'b0) : word_of(beat1_pair, 1'b1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat1_pend <= 1'b0;
      beat1_pair <= '0;
    end else if (cmd_slot) begin
      beat1_pend <= !wr_sel_n;
      beat1_pair <= addr;
    end else begin
      beat1_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/qdr_store.sv
module qdr_store #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW:0]   waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] rpair,
  output logic [DW-1:0] rd0,
  output logic [DW-1:0] rd1
);
  localparam int NWORDS = 2 ** (AW + 1);

  logic [DW-1:0] mem [NWORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // Snapshot ports: both beats of a pair, before any write at this edge
  assign rd0 = mem[{rpair, 1'b0}];
  assign rd1 = mem[{rpair, 1'b1}];
endmodule

// File: rtl/qdr_rd_path.sv
module qdr_rd_path #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_slot,
  input  logic          rd_start,
  input  logic [DW-1:0] rd0,
  input  logic [DW-1:0] rd1,
  output logic [DW-1:0] q_data,
  output logic          q_oe
);
  logic          resp_pend;
  logic [DW-1:0] snap0, snap1, hold1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_pend <= 1'b0;
      snap0     <= '0;
      snap1     <= '0;
      hold1     <= '0;
      q_data    <= '0;
      q_oe      <= 1'b0;
    end else if (cmd_slot) begin
      resp_pend <= rd_start;
      if (rd_start) begin
        snap0 <= rd0;
        snap1 <= rd1;
      end
      q_oe   <= resp_pend;
      q_data <= snap0;
      hold1  <= snap1;
    end else begin
      q_data <= hold1;
    end
  end
endmodule

// File: rtl/qdr_b2_sram.sv
module qdr_b2_sram
  import qdr_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_sel_n,
  input  logic          wr_sel_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rd_oe
);
  slot_e         slot;
  logic          cmd_slot;
  logic          rd_start;
  logic          wr_start;
  logic          mem_we;
  logic [AW:0]   mem_waddr;
  logic [DW-1:0] rd0, rd1;
  logic [DW-1:0] q_data;

  assign cmd_slot = (slot == SLOT_CMD);
  assign rd_start = cmd_slot && !rd_sel_n;
  assign wr_start = cmd_slot && !wr_sel_n;

  qdr_phase u_phase (.clk(clk), .rst_n(rst_n), .slot(slot));

  qdr_wr_path #(.AW(AW)) u_wr (
    .clk(clk), .rst_n(rst_n), .cmd_slot(cmd_slot), .wr_sel_n(wr_sel_n),
    .addr(addr), .we(mem_we), .waddr(mem_waddr)
  );

  qdr_store #(.AW(AW), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_waddr), .wdata(wdata),
    .rpair(addr), .rd0(rd0), .rd1(rd1)
  );

  qdr_rd_path #(.DW(DW)) u_rd (
    .clk(clk), .rst_n(rst_n), .cmd_slot(cmd_slot), .rd_start(rd_start),
    .rd0(rd0), .rd1(rd1), .q_data(q_data), .q_oe(rd_oe)
  );

  assign rdata = rd_oe ? q_data : 'z;
endmodule

// File: rtl/qdr_b2_sram_chk.sv
module qdr_b2_sram_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_slot,
  input logic          rd_start,
  input logic          wr_start,
  input logic          mem_we,
  input logic [AW:0]   mem_waddr,
  input logic [AW-1:0] addr,
  input logic          rd_oe
);
  p_slot_alt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_slot |=> !cmd_slot);

  p_beat0_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |-> (mem_we && mem_waddr == {addr, 1'b0}));

  p_beat1_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_slot && mem_we) |-> ($past(wr_start) && mem_waddr == {$past(addr), 1'b1}));

  p_nop_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_slot && !$past(wr_start)) |-> !mem_we);

  p_resp_slot0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |-> ##3 rd_oe);

  p_resp_slot1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |-> ##4 rd_oe);

  p_oe_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe |-> ($past(rd_start, 3) || $past(rd_start, 4)));
endmodule

bind qdr_b2_sram qdr_b2_sram_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_slot(cmd_slot), .rd_start(rd_start),
  .wr_start(wr_start), .mem_we(mem_we), .mem_waddr(mem_waddr),
  .addr(addr), .rd_oe(rd_oe)
);

// File: tb/tb_qdr_b2_sram.sv
module tb_qdr_b2_sram;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int NPAIR = 2 ** AW;

  logic          clk = 1'b0;
  logic          clk_run = 1'b1;
  logic          rst_n = 1'b0;
  logic          rd_sel_n = 1'b1;
  logic          wr_sel_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  wire  [DW-1:0] rdata;
  wire           rd_oe;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [DW-1:0] model [2*NPAIR];
  bit            exp_p = 0;
  logic [DW-1:0] exp0 = '0, exp1 = '0;

  qdr_b2_sram #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rd_oe(rd_oe)
  );

  always #(CLK_PERIOD/2) if (clk_run) clk = ~clk;

  function automatic int widx(int pair, int beat);
    return pair * 2 + beat;
  endfunction

  task automatic check_out(string tag, bit p, logic [DW-1:0] d);
    checks++;
    if (rd_oe !== p) begin
      errors++;
      $display("FAIL %s rd_oe actual=%0b expected=%0b", tag, rd_oe, p);
    end else if (p && rdata !== d) begin
      errors++;
      $display("FAIL %s rdata actual=%h expected=%h", tag, rdata, d);
    end
  endtask

  // One command cycle, entered and left at a falling edge
  task automatic kcycle(string tag, bit rs, bit ws, int a,
                        logic [DW-1:0] d0, logic [DW-1:0] d1, bit stop);
    bit            np;
    logic [DW-1:0] n0, n1;
    rd_sel_n = rs; wr_sel_n = ws; addr = a[AW-1:0]; wdata = d0;
    np = !rs;
    n0 = model[widx(a, 0)];
    n1 = model[widx(a, 1)];
    if (!ws) begin
      model[widx(a, 0)] = d0;
      model[widx(a, 1)] = d1;
    end
    @(posedge clk); @(negedge clk);
    check_out(tag, exp_p, exp0);
    wdata = d1;
    if (stop) begin
      clk_run = 1'b0;
      #(CLK_PERIOD * 12);
      check_out("R10", exp_p, exp0);
      clk_run = 1'b1;
    end
    @(posedge clk); @(negedge clk);
    check_out(tag, exp_p, exp1);
    exp_p = np; exp0 = n0; exp1 = n1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 2*NPAIR; i++) model[i] = '0;
    repeat (4) @(negedge clk);
    check_out("R1", 1'b0, '0);
    rst_n = 1'b1;
    // R1: contents zero after reset
    kcycle("R1", 0, 1, 5, 16'h0, 16'h0, 0);
    kcycle("R1", 1, 1, 0, 16'h0, 16'h0, 0);
    // R2 R3: write then read back
    kcycle("R2", 1, 0, 3, 16'hA1B2, 16'hC3D4, 0);
    kcycle("R3", 0, 1, 3, 16'h0, 16'h0, 0);
    kcycle("R5", 1, 1, 0, 16'h0, 16'h0, 0);
    kcycle("R5", 1, 1, 0, 16'h0, 16'h0, 0);
    // R6: idle cycle with live write data must not store
    kcycle("R6", 1, 1, 3, 16'hDEAD, 16'hBEEF, 0);
    kcycle("R6", 0, 1, 3, 16'h0, 16'h0, 0);
    kcycle("R6", 1, 1, 0, 16'h0, 16'h0, 0);
    // R7: read and write to the same pair in one cycle
    kcycle("R7", 0, 0, 3, 16'h1111, 16'h2222, 0);
    kcycle("R7", 0, 1, 3, 16'h0, 16'h0, 0);
    kcycle("R7", 1, 1, 0, 16'h0, 16'h0, 0);
    // R9: top pair address leaves pair 0 alone
    kcycle("R9", 1, 0, 0, 16'h5A5A, 16'hA5A5, 0);
    kcycle("R9", 1, 0, NPAIR-1, 16'h7777, 16'h8888, 0);
    kcycle("R9", 0, 1, 0, 16'h0, 16'h0, 0);
    kcycle("R9", 0, 1, NPAIR-1, 16'h0, 16'h0, 0);
    // R8: back-to-back reads
    kcycle("R8", 0, 1, 3, 16'h0, 16'h0, 0);
    kcycle("R8", 0, 1, 0, 16'h0, 16'h0, 0);
    kcycle("R8", 0, 1, NPAIR-1, 16'h0, 16'h0, 0);
    kcycle("R8", 1, 1, 0, 16'h0, 16'h0, 0);
    // R10: clock stop during a response
    kcycle("R10", 0, 1, 0, 16'h0, 16'h0, 0);
    kcycle("R10", 1, 1, 0, 16'h0, 16'h0, 1);
    kcycle("R10", 0, 0, 2, 16'h3C3C, 16'h4B4B, 0);
    kcycle("R10", 1, 1, 0, 16'h0, 16'h0, 0);
    // R4: random traffic in a narrow window to force collisions
    for (int i = 0; i < 600; i++) begin
      int a;
      a = ($urandom % 4 == 0) ? int'($urandom % NPAIR) : int'($urandom % 3);
      kcycle("R4", bit'($urandom % 3 == 0), bit'($urandom % 2),
             a, DW'($urandom), DW'($urandom), 0);
    end
    kcycle("R5", 1, 1, 0, 16'h0, 16'h0, 0);
    kcycle("R5", 1, 1, 0, 16'h0, 16'h0, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule